// File: doc/BRIEF.md
# Nested Priority Event Arbiter

This block decides which processor event is serviced next. There are sixteen event levels in a fixed order, and level 0 is the most urgent. Requests arrive on per-level lines, on two non-maskable-interrupt sources, on a synchronous exception line and on a two-bit software raise. The block latches each request as pending. It applies an enable mask to the maskable levels. It then selects the most urgent eligible pending level, but only when that level is more urgent than everything currently being serviced. When it selects a level, it raises a take strobe and reports that level.

A taken level is added to an in-service vector, and the most urgent bit of that vector is the current level. A return pulse ends service of the current level, and the level it interrupted becomes current again. When the reset event is taken, the whole state is wiped and only the reset level is left in service.

The fixed order of the levels is: 0 emulation, 1 reset, 2 non-maskable interrupt, 3 exception, 4 unused slot, 5 hardware error, 6 core timer, 7 to 15 general purpose. Levels 14 and 15 are the software levels.

Top module: `evt_controller`

## Requirements
- R1: While `rstN` is low, and after it is released with no further stimulus, `pendingVec` and `inService` are zero and `takeEvt` and `curValid` are low.
- R2: When several levels are eligible at once, the level with the lowest number wins and is reported on `evtLevel`.
- R3: A pending level is taken only when no level is in service, or when its number is strictly below `curLevel`. Otherwise it stays pending until service ends and it becomes eligible.
- R4: A rising edge on `evtReq[n]` sets pending bit n at the next clock edge. `takeEvt` is combinational from the pending state. At the clock edge where a take is reported, the pending bit of the taken level clears and its in-service bit sets.
- R5: Level 2 is requested by a rising edge of (`nmiPin` OR `wdogNmi`), in addition to `evtReq[2]`.
- R6: When `excReq` is high and level 3 is eligible, `takeEvt` rises in that same cycle with `evtLevel` = 3. If level 3 is not eligible, pending bit 3 sets at the clock edge instead.
- R7: `intEnable[i]` enables level 5+i, for i = 0 to 10, and a cleared bit holds that level pending without taking it. Levels 0 to 3 are never masked.
- R8: At the clock edge, `swRaise[0]` sets pending bit 14 and `swRaise[1]` sets pending bit 15.
- R9: Level 4 never becomes pending, in service or taken, whatever is applied on `evtReq[4]`.
- R10: `retEvt` clears the lowest-numbered in-service bit at the clock edge, which makes the interrupted level current again. With nothing in service it has no effect.
- R11: At the clock edge where level 1 is taken, `inService` becomes exactly bit 1 and every pending bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtReq | input | 16 | Per-level request lines, edge detected |
| nmiPin | input | 1 | External non-maskable interrupt request |
| wdogNmi | input | 1 | Watchdog non-maskable interrupt request |
| excReq | input | 1 | Synchronous exception request, one-cycle pulse |
| swRaise | input | 2 | Software raise for levels 14 and 15 |
| intEnable | input | 11 | Enable bits for levels 5 to 15 |
| retEvt | input | 1 | Return-from-event pulse |
| takeEvt | output | 1 | An event is taken this cycle |
| evtLevel | output | 4 | Level being taken |
| curLevel | output | 4 | Most urgent level in service |
| curValid | output | 1 | At least one level is in service |
| inService | output | 16 | In-service vector |
| pendingVec | output | 16 | Pending vector |

## Verification
The bench builds the block with its default sixteen levels and all eleven enable bits. At that size a full pairwise sweep is practical. Every ordered pair of the thirteen levels that can be requested is driven as "A in service, then B requested", which covers the complete preempt-or-wait table, including equal levels. This covers R3. Separate directed sequences cover masking, the same-cycle exception path, the software levels, the unused slot, three-deep nesting with an extra return when idle, and the wipe on reset.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int LEVELS = 16;
  localparam int LVLW = $clog2(LEVELS);
  localparam int LVL_RST = 1;
  localparam int LVL_NMI = 2;
  localparam int LVL_EXC = 3;
  localparam int LVL_RSV = 4;
  localparam int FIRST_MASKABLE = 5;
  localparam int MASKW = LEVELS - FIRST_MASKABLE;
  localparam int SW_BASE = 14;
  localparam int SWW = LEVELS - SW_BASE;

  typedef logic [LEVELS-1:0] lvlVec_t;

  typedef struct packed {
    logic            take;
    logic [LVLW-1:0] winLevel;
    logic            pop;
    logic            rstTake;
  } ctlStrobe_t;

  // lowest set index (most urgent); zero when vector is empty
  function automatic logic [LVLW-1:0] firstSet(lvlVec_t v);
    logic [LVLW-1:0] r;
    r = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (v[i]) r = LVLW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/evtc_arbiter.sv
module evtc_arbiter
  import evtc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  lvlVec_t             pendVec,
  input  lvlVec_t             svcVec,
  input  logic                excReq,
  input  logic [MASKW-1:0]    intEnable,
  input  logic                retEvt,
  output ctlStrobe_t          strobe,
  output logic [LVLW-1:0]     curLevel,
  output logic                curValid
);
  lvlVec_t allowVec, aboveVec, candVec, eligVec;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : gAllow
      if (g < FIRST_MASKABLE) begin : gFixed
        assign allowVec[g] = (g != LVL_RSV);
      end else begin : gMask
        assign allowVec[g] = intEnable[g - FIRST_MASKABLE];
      end
      assign aboveVec[g] = !curValid || (LVLW'(g) < curLevel);
    end
  endgenerate

  assign curValid = |svcVec;
  assign curLevel = firstSet(svcVec);
  assign candVec  = pendVec | (lvlVec_t'(excReq) << LVL_EXC);
  assign eligVec  = candVec & allowVec & aboveVec;

  always_comb begin
    strobe.take     = |eligVec;
    strobe.winLevel = firstSet(eligVec);
    strobe.pop      = retEvt && curValid;
    strobe.rstTake  = strobe.take && (strobe.winLevel == LVLW'(LVL_RST));
  end

  // R3
  take_above_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> (!curValid || strobe.winLevel < curLevel));

  // R9
  rsv_never_won_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> strobe.winLevel != LVLW'(LVL_RSV));
endmodule

// File: rtl/evtc_state.sv
module evtc_state
  import evtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  lvlVec_t          evtReq,
  input  logic             nmiPin,
  input  logic             wdogNmi,
  input  logic             excReq,
  input  logic [SWW-1:0]   swRaise,
  input  ctlStrobe_t       strobe,
  output lvlVec_t          pendVec,
  output lvlVec_t          svcVec
);
  lvlVec_t reqNow, reqQ, setVec, takeOh, popOh;

  assign reqNow = evtReq | (lvlVec_t'(nmiPin | wdogNmi) << LVL_NMI);
  assign setVec = ((reqNow & ~reqQ)
                 | (lvlVec_t'(excReq) << LVL_EXC)
                 | (lvlVec_t'(swRaise) << SW_BASE))
                 & ~(lvlVec_t'(1) << LVL_RSV);
  assign takeOh = strobe.take ? (lvlVec_t'(1) << strobe.winLevel) : '0;
  assign popOh  = strobe.pop ? (svcVec & (~svcVec + lvlVec_t'(1))) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= '0;
      pendVec <= '0;
      svcVec  <= '0;
    end else begin
      reqQ <= reqNow;
      if (strobe.rstTake) begin
        pendVec <= '0;
        svcVec  <= lvlVec_t'(1) << LVL_RST;
      end else begin
        pendVec <= (pendVec | setVec) & ~takeOh;
        svcVec  <= (svcVec & ~popOh) | takeOh;
      end
    end
  end

  // R4
  take_sets_svc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> svcVec[$past(strobe.winLevel)]);

  // R11
  rst_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstTake |=> (svcVec == (lvlVec_t'(1) << LVL_RST)) && (pendVec == '0));

  // R10
  pop_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.take) |=> $countones(svcVec) == $countones($past(svcVec)) - 1);

  // R9
  rsv_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendVec[LVL_RSV] && !svcVec[LVL_RSV]);
endmodule

// File: rtl/evt_controller.sv
module evt_controller
  import evtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEVELS-1:0] evtReq,
  input  logic              nmiPin,
  input  logic              wdogNmi,
  input  logic              excReq,
  input  logic [SWW-1:0]    swRaise,
  input  logic [MASKW-1:0]  intEnable,
  input  logic              retEvt,
  output logic              takeEvt,
  output logic [LVLW-1:0]   evtLevel,
  output logic [LVLW-1:0]   curLevel,
  output logic              curValid,
  output logic [LEVELS-1:0] inService,
  output logic [LEVELS-1:0] pendingVec
);
  ctlStrobe_t strobe;
  lvlVec_t    pendVec, svcVec;

  evtc_arbiter uArb (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .svcVec(svcVec),
    .excReq(excReq), .intEnable(intEnable), .retEvt(retEvt),
    .strobe(strobe), .curLevel(curLevel), .curValid(curValid)
  );

  evtc_state uState (
    .clk(clk), .rstN(rstN), .evtReq(evtReq), .nmiPin(nmiPin),
    .wdogNmi(wdogNmi), .excReq(excReq), .swRaise(swRaise),
    .strobe(strobe), .pendVec(pendVec), .svcVec(svcVec)
  );

  assign takeEvt    = strobe.take;
  assign evtLevel   = strobe.winLevel;
  assign inService  = svcVec;
  assign pendingVec = pendVec;
endmodule

// File: tb/evt_controller_test.sv
`timescale 1ns/1ps
module evt_controller_test;
  logic        clk = 0, rstN = 0;
  logic [15:0] evtReq = '0;
  logic        nmiPin = 0, wdogNmi = 0, excReq = 0, retEvt = 0;
  logic [1:0]  swRaise = '0;
  logic [10:0] intEnable = '1;
  logic        takeEvt, curValid;
  logic [3:0]  evtLevel, curLevel;
  logic [15:0] inService, pendingVec;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_controller uut (
    .clk(clk), .rstN(rstN), .evtReq(evtReq), .nmiPin(nmiPin), .wdogNmi(wdogNmi),
    .excReq(excReq), .swRaise(swRaise), .intEnable(intEnable), .retEvt(retEvt),
    .takeEvt(takeEvt), .evtLevel(evtLevel), .curLevel(curLevel), .curValid(curValid),
    .inService(inService), .pendingVec(pendingVec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ret();
    retEvt = 1; cyc(); retEvt = 0;
  endtask

  task automatic reqLevel(input int l);
    evtReq = 16'(1) << l; cyc(); evtReq = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk(pendingVec == 0 && inService == 0 && !takeEvt && !curValid, "R1 in reset", inService, 0);
    rstN = 1; cyc(); cyc();
    chk(pendingVec == 0 && inService == 0 && !takeEvt && !curValid, "R1 after release", pendingVec, 0);

    // R3/R4 pairwise sweep: A in service, then B requested
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a == 3 || a == 4) continue;
      for (int b = 0; b < 16; b++) begin
        if (b == 1 || b == 3 || b == 4) continue;
        reqLevel(a);
        chk(takeEvt && evtLevel == a, "R4 take A", evtLevel, a);
        cyc();
        chk(inService == (16'(1) << a) && pendingVec == 0, "R4 A in service", inService, 16'(1) << a);
        reqLevel(b);
        if (b < a) begin
          chk(takeEvt && evtLevel == b, "R3 preempt", evtLevel, b);
          cyc();
          chk(curLevel == b, "R3 nested cur", curLevel, b);
          ret();
          chk(curLevel == a && inService == (16'(1) << a), "R10 resume A", curLevel, a);
          ret();
        end else begin
          chk(!takeEvt && pendingVec == (16'(1) << b), "R3 wait", takeEvt, 0);
          ret();
          chk(takeEvt && evtLevel == b, "R3 taken after return", evtLevel, b);
          cyc();
          ret();
        end
        chk(inService == 0 && pendingVec == 0 && !takeEvt, "R10 idle", inService, 0);
      end
    end

    // R2 simultaneous requests
    evtReq = 16'h1080; cyc(); evtReq = '0;
    chk(takeEvt && evtLevel == 7, "R2 lowest wins", evtLevel, 7);
    cyc(); ret();
    chk(takeEvt && evtLevel == 12, "R2 loser follows", evtLevel, 12);
    cyc(); ret();

    // R5 both NMI sources
    nmiPin = 1; cyc(); nmiPin = 0;
    chk(takeEvt && evtLevel == 2, "R5 pin", evtLevel, 2);
    cyc(); ret();
    wdogNmi = 1; cyc(); wdogNmi = 0;
    chk(takeEvt && evtLevel == 2, "R5 watchdog", evtLevel, 2);
    cyc();

    // R6 exception blocked while NMI in service, then same-cycle take when idle
    excReq = 1; #1;
    chk(!takeEvt, "R6 blocked", takeEvt, 0);
    cyc(); excReq = 0;
    chk(pendingVec == 16'h0008, "R6 held pending", pendingVec, 16'h0008);
    ret();
    chk(takeEvt && evtLevel == 3, "R6 taken after return", evtLevel, 3);
    cyc(); ret();
    excReq = 1; #1;
    chk(takeEvt && evtLevel == 3, "R6 same cycle", evtLevel, 3);
    cyc(); excReq = 0;
    chk(inService == 16'h0008 && pendingVec == 0, "R6 in service", inService, 16'h0008);
    ret();

    // R7 masking
    intEnable = '0;
    reqLevel(9);
    chk(!takeEvt && pendingVec == 16'h0200, "R7 masked holds", pendingVec, 16'h0200);
    wdogNmi = 1; cyc(); wdogNmi = 0;
    chk(takeEvt && evtLevel == 2, "R7 NMI unmaskable", evtLevel, 2);
    cyc(); ret();
    chk(!takeEvt, "R7 still masked", takeEvt, 0);
    intEnable = 11'(1) << 4; #1;
    chk(takeEvt && evtLevel == 9, "R7 unmask takes", evtLevel, 9);
    cyc(); ret(); intEnable = '1;

    // R8 software raise
    swRaise = 2'b11; cyc(); swRaise = '0;
    chk(pendingVec == 16'hC000 && takeEvt && evtLevel == 14, "R8 both raised", pendingVec, 16'hC000);
    cyc();
    chk(inService == 16'h4000 && !takeEvt, "R8 15 waits", inService, 16'h4000);
    ret();
    chk(takeEvt && evtLevel == 15, "R8 15 taken", evtLevel, 15);
    cyc(); ret();

    // R9 unused slot
    reqLevel(4); #1;
    chk(pendingVec == 0 && !takeEvt, "R9 ignored", pendingVec, 0);
    cyc();
    chk(inService == 0 && !takeEvt, "R9 nothing in service", inService, 0);

    // R10 three-deep nesting
    reqLevel(12); cyc();
    reqLevel(9); cyc();
    reqLevel(7); cyc();
    chk(inService == 16'h1280 && curLevel == 7, "R10 three deep", inService, 16'h1280);
    ret();
    chk(curLevel == 9, "R10 pop to 9", curLevel, 9);
    ret();
    chk(curLevel == 12, "R10 pop to 12", curLevel, 12);
    ret();
    chk(!curValid && inService == 0, "R10 empty", inService, 0);
    ret();
    chk(!curValid && inService == 0 && pendingVec == 0, "R10 idle return", inService, 0);

    // R11 reset event wipes state
    reqLevel(10); cyc();
    intEnable = ~(11'(1) << 7);
    reqLevel(12);
    chk(pendingVec == 16'h1000, "R11 setup pending", pendingVec, 16'h1000);
    reqLevel(1);
    chk(takeEvt && evtLevel == 1, "R11 reset taken", evtLevel, 1);
    cyc();
    chk(inService == 16'h0002 && pendingVec == 0, "R11 wiped", inService, 16'h0002);
    ret(); intEnable = '1;
    chk(inService == 0, "R11 return", inService, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule